// File: doc/BRIEF.md
# Card Data-Path Control Register

A single memory-mapped control word that configures the data-transfer state machine of a card interface. Software writes and reads it over a minimal register port; the block decodes the word into individual control lines for the data path (transfer start, direction, transfer mode, block-size code and decoded byte length, read-wait controls, card interrupt enable, boot-acknowledge enable) and produces a one-cycle FIFO flush strobe.

The block enforces the access rules itself. While the data state machine reports that it is busy, configuration fields ignore software writes. Several bits are owned partly by hardware: the transfer-start bit drops when the transfer finishes, the read-wait stop bit drops when the state machine leaves its read-wait state, and the FIFO reset bit is accepted only during an active transfer with DMA off. That bit is cleared as soon as the state machine goes idle, and it flushes the FIFO only when a transfer error or hold is present.

Top module: `card_dctrl_reg`

## Requirements
- R1: After reset every field is 0, `bus_rdata` reads 0 at the register address, and `fifo_flush` is 0.
- R2: While `dpsm_active`=0, a write to `REG_ADDR` loads the configuration fields at these bit positions: block code [7:4], transfer mode [9:8], direction [12] (1 = card to host), transfer start [13], read-wait mode [14] (1 = stop card clock, 0 = data-line signalling), card interrupt enable [15], boot-ack enable [16]. Reads return the word at the same positions.
- R3: While `dpsm_active`=1, writes leave bits [16:4] unchanged.
- R4: `xfer_done`=1 clears transfer start on the next edge, even when a write sets it in the same cycle.
- R5: Read-wait start [1] and read-wait stop [2] accept writes in any state; `rw_exit`=1 clears read-wait stop and wins over a same-cycle write.
- R6: FIFO reset [0] accepts a write only when `dpsm_active`=1 and `dma_en`=0.
- R7: `fifo_flush` is high for exactly one cycle: the first cycle in which FIFO reset reads 1 and `err_or_hold`=1. It does not fire without `err_or_hold`, and it can fire again only after FIFO reset has been cleared and set again.
- R8: FIFO reset reads 0 on the cycle after any cycle with `dpsm_active`=0.
- R9: `blk_len` equals 2 to the power of the block code when the code is at most `MAX_BLK_LOG2`, and 0 otherwise.
- R10: Writes to any other address change nothing; reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational on address) |
| dpsm_active | input | 1 | Data state machine busy |
| xfer_done | input | 1 | Transfer completed event |
| rw_exit | input | 1 | Left read-wait state (to wait-receive or idle) |
| err_or_hold | input | 1 | Transfer error or hold present |
| dma_en | input | 1 | DMA enabled level |
| xfer_en | output | 1 | Start transfer without a command |
| dir_c2h | output | 1 | 1 = card to host |
| xfer_mode | output | 2 | Transfer mode code |
| blk_code | output | 4 | Block-size code |
| blk_len | output | MAX_BLK_LOG2+1 | Decoded block length in bytes |
| rw_start | output | 1 | Read-wait start |
| rw_stop | output | 1 | Read-wait stop |
| rw_clk_stop | output | 1 | Read-wait by stopping clock |
| sdio_irq_en | output | 1 | Card interrupt enable |
| boot_ack_en | output | 1 | Expect boot acknowledge |
| fifo_flush | output | 1 | One-cycle FIFO flush strobe |

## Verification
The bench builds the block with `REG_ADDR`=2 and `ADDR_W`=4, so that address 0 and other addresses are genuine misses and the address decode is exercised rather than trivially matching. `MAX_BLK_LOG2` stays at 14 and `HW_WINS` at 1, which puts code 15 beyond the decode limit. It also makes the same-cycle conflicts between hardware clears and software writes observable, with hardware taking priority.

// File: rtl/dctrl_pkg.sv
package dctrl_pkg;
   localparam int B_FRST   = 0;
   localparam int B_RWSTA  = 1;
   localparam int B_RWSTO  = 2;
   localparam int B_BLK_LO = 4;
   localparam int B_MODE_LO = 8;
   localparam int B_DIR    = 12;
   localparam int B_EN     = 13;
   localparam int B_RWMOD  = 14;
   localparam int B_SDIO   = 15;
   localparam int B_BOOT   = 16;
   localparam int USED_W   = 17;

   typedef struct packed {
      logic       dir;
      logic [1:0] mode;
      logic [3:0] blk;
      logic       rwmod;
      logic       sdio;
      logic       boot;
   } cfg_t;

   function automatic cfg_t cfg_from_word(input logic [USED_W-1:0] w);
      cfg_t c;
      c.dir   = w[B_DIR];
      c.mode  = w[B_MODE_LO +: 2];
      c.blk   = w[B_BLK_LO +: 4];
      c.rwmod = w[B_RWMOD];
      c.sdio  = w[B_SDIO];
      c.boot  = w[B_BOOT];
      return c;
   endfunction
endpackage

// File: rtl/dctrl_cfg_fields.sv
module dctrl_cfg_fields
   import dctrl_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_hit,
   input  logic [USED_W-1:0]     wword,
   input  logic                  dpsm_active,
   output cfg_t                  cfg
);
   cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (wr_hit && !dpsm_active)
         cfg_q <= cfg_from_word(wword);
   end

   assign cfg = cfg_q;
endmodule

// File: rtl/dctrl_hw_bits.sv
module dctrl_hw_bits
   import dctrl_pkg::*;
#(
   parameter bit HW_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [USED_W-1:0] wword,
   input  logic              dpsm_active,
   input  logic              xfer_done,
   input  logic              rw_exit,
   output logic              xfer_en,
   output logic              rw_start,
   output logic              rw_stop
);
   logic en_q, sta_q, sto_q;
   logic en_wr;

   assign en_wr = wr_hit && !dpsm_active;

   generate
      if (HW_WINS) begin : g_hw_first
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q  <= 1'b0;
               sto_q <= 1'b0;
            end else begin
               if (xfer_done)  en_q <= 1'b0;
               else if (en_wr) en_q <= wword[B_EN];
               if (rw_exit)    sto_q <= 1'b0;
               else if (wr_hit) sto_q <= wword[B_RWSTO];
            end
         end
      end else begin : g_sw_first
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q  <= 1'b0;
               sto_q <= 1'b0;
            end else begin
               if (en_wr)          en_q <= wword[B_EN];
               else if (xfer_done) en_q <= 1'b0;
               if (wr_hit)         sto_q <= wword[B_RWSTO];
               else if (rw_exit)   sto_q <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      sta_q <= 1'b0;
      else if (wr_hit) sta_q <= wword[B_RWSTA];
   end

   assign xfer_en  = en_q;
   assign rw_start = sta_q;
   assign rw_stop  = sto_q;
endmodule

// File: rtl/dctrl_flush.sv
module dctrl_flush (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wbit,
   input  logic dpsm_active,
   input  logic dma_en,
   input  logic err_or_hold,
   output logic fifo_rst,
   output logic fifo_flush
);
   logic rst_q, fired_q, pulse;

   assign pulse = rst_q && err_or_hold && !fired_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    rst_q <= 1'b0;
      else if (!dpsm_active)         rst_q <= 1'b0;
      else if (wr_hit && !dma_en)    rst_q <= wbit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      fired_q <= 1'b0;
      else if (!rst_q) fired_q <= 1'b0;
      else if (pulse)  fired_q <= 1'b1;
   end

   assign fifo_rst   = rst_q;
   assign fifo_flush = pulse;
endmodule

// File: rtl/card_dctrl_reg.sv
module card_dctrl_reg
   import dctrl_pkg::*;
#(
   parameter int          ADDR_W       = 4,
   parameter int          DATA_W       = 32,
   parameter int          MAX_BLK_LOG2 = 14,
   parameter logic [31:0] REG_ADDR     = 32'd0,
   parameter bit          HW_WINS      = 1'b1,
   localparam int         LEN_W        = MAX_BLK_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dpsm_active,
   input  logic              xfer_done,
   input  logic              rw_exit,
   input  logic              err_or_hold,
   input  logic              dma_en,
   output logic              xfer_en,
   output logic              dir_c2h,
   output logic [1:0]        xfer_mode,
   output logic [3:0]        blk_code,
   output logic [LEN_W-1:0]  blk_len,
   output logic              rw_start,
   output logic              rw_stop,
   output logic              rw_clk_stop,
   output logic              sdio_irq_en,
   output logic              boot_ack_en,
   output logic              fifo_flush
);
   generate
      if (DATA_W < USED_W) begin : g_bad_dw
         $error("DATA_W too small for control word");
      end
      if (MAX_BLK_LOG2 < 1 || MAX_BLK_LOG2 > 15) begin : g_bad_blk
         $error("MAX_BLK_LOG2 out of range");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W out of range");
      end
   endgenerate

   logic              hit, wr_hit, fifo_rst_q;
   logic [USED_W-1:0] wword, rword;
   cfg_t              cfg;

   assign hit    = (bus_addr == REG_ADDR[ADDR_W-1:0]);
   assign wr_hit = bus_wr && hit;
   assign wword  = bus_wdata[USED_W-1:0];

   logic unused_wbits;
   generate
      if (DATA_W > USED_W) begin : g_hi
         assign unused_wbits = ^bus_wdata[DATA_W-1:USED_W];
      end else begin : g_nohi
         assign unused_wbits = 1'b0;
      end
   endgenerate

   dctrl_cfg_fields u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wword(wword),
      .dpsm_active(dpsm_active), .cfg(cfg)
   );

   dctrl_hw_bits #(.HW_WINS(HW_WINS)) u_hw (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wword(wword),
      .dpsm_active(dpsm_active), .xfer_done(xfer_done), .rw_exit(rw_exit),
      .xfer_en(xfer_en), .rw_start(rw_start), .rw_stop(rw_stop)
   );

   dctrl_flush u_fl (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wbit(wword[B_FRST]),
      .dpsm_active(dpsm_active), .dma_en(dma_en), .err_or_hold(err_or_hold),
      .fifo_rst(fifo_rst_q), .fifo_flush(fifo_flush)
   );

   assign dir_c2h     = cfg.dir;
   assign xfer_mode   = cfg.mode;
   assign blk_code    = cfg.blk;
   assign rw_clk_stop = cfg.rwmod;
   assign sdio_irq_en = cfg.sdio;
   assign boot_ack_en = cfg.boot;

   always_comb begin
      blk_len = '0;
      if (int'(cfg.blk) <= MAX_BLK_LOG2)
         blk_len = LEN_W'(1) << cfg.blk;
   end

   always_comb begin
      rword              = '0;
      rword[B_FRST]      = fifo_rst_q;
      rword[B_RWSTA]     = rw_start;
      rword[B_RWSTO]     = rw_stop;
      rword[B_BLK_LO+:4] = cfg.blk;
      rword[B_MODE_LO+:2] = cfg.mode;
      rword[B_DIR]       = cfg.dir;
      rword[B_EN]        = xfer_en;
      rword[B_RWMOD]     = cfg.rwmod;
      rword[B_SDIO]      = cfg.sdio;
      rword[B_BOOT]      = cfg.boot;
      bus_rdata          = '0;
      if (hit)
         bus_rdata[USED_W-1:0] = rword;
   end
endmodule

// File: rtl/dctrl_reg_chk.sv
module dctrl_reg_chk #(
   parameter bit HW_WINS = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       dpsm_active,
   input logic       xfer_done,
   input logic       rw_exit,
   input logic       err_or_hold,
   input logic       dma_en,
   input logic       xfer_en,
   input logic       rw_stop,
   input logic       fifo_rst_q,
   input logic       fifo_flush,
   input logic       dir_c2h,
   input logic [1:0] xfer_mode,
   input logic [3:0] blk_code,
   input logic       rw_clk_stop,
   input logic       sdio_irq_en,
   input logic       boot_ack_en
);
   // R3
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dpsm_active |=> $stable({dir_c2h, xfer_mode, blk_code, rw_clk_stop, sdio_irq_en, boot_ack_en}));

   generate
      if (HW_WINS) begin : g_hw
         // R4
         done_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_done |=> !xfer_en);
         // R5
         exit_clears_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rw_exit |=> !rw_stop);
      end
   endgenerate

   // R6
   dma_blocks_frst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && !fifo_rst_q) |=> !fifo_rst_q);

   // R7
   flush_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> (err_or_hold && fifo_rst_q));

   // R7
   flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |=> !fifo_flush);

   // R8
   idle_clears_frst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dpsm_active |=> !fifo_rst_q);
endmodule

bind card_dctrl_reg dctrl_reg_chk #(.HW_WINS(HW_WINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .dpsm_active(dpsm_active), .xfer_done(xfer_done),
   .rw_exit(rw_exit), .err_or_hold(err_or_hold), .dma_en(dma_en),
   .xfer_en(xfer_en), .rw_stop(rw_stop), .fifo_rst_q(fifo_rst_q),
   .fifo_flush(fifo_flush), .dir_c2h(dir_c2h), .xfer_mode(xfer_mode),
   .blk_code(blk_code), .rw_clk_stop(rw_clk_stop), .sdio_irq_en(sdio_irq_en),
   .boot_ack_en(boot_ack_en)
);

// File: tb/tb_card_dctrl_reg.sv
module tb_card_dctrl_reg;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int LEN_W  = 15;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_wr;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic dpsm_active, xfer_done, rw_exit, err_or_hold, dma_en;
   logic xfer_en, dir_c2h, rw_start, rw_stop, rw_clk_stop, sdio_irq_en, boot_ack_en, fifo_flush;
   logic [1:0] xfer_mode;
   logic [3:0] blk_code;
   logic [LEN_W-1:0] blk_len;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   card_dctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BLK_LOG2(14),
                    .REG_ADDR(32'd2), .HW_WINS(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dpsm_active(dpsm_active),
      .xfer_done(xfer_done), .rw_exit(rw_exit), .err_or_hold(err_or_hold),
      .dma_en(dma_en), .xfer_en(xfer_en), .dir_c2h(dir_c2h), .xfer_mode(xfer_mode),
      .blk_code(blk_code), .blk_len(blk_len), .rw_start(rw_start), .rw_stop(rw_stop),
      .rw_clk_stop(rw_clk_stop), .sdio_irq_en(sdio_irq_en), .boot_ack_en(boot_ack_en),
      .fifo_flush(fifo_flush)
   );

   typedef struct packed {
      logic        act;
      logic        dma;
      logic        wr;
      logic [3:0]  addr;
      logic [31:0] wdata;
      logic        done;
      logic        rwx;
      logic        err;
      logic        exp_flush;
      logic [31:0] exp_rd;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,1'b1,4'd2,32'h0001F291,1'b0,1'b0,1'b0,1'b0,32'h0001F290,8'd2},
      '{1'b1,1'b0,1'b1,4'd2,32'h00000000,1'b0,1'b0,1'b0,1'b0,32'h0001F290,8'd3},
      '{1'b1,1'b1,1'b1,4'd2,32'h00000007,1'b0,1'b0,1'b0,1'b0,32'h0001F296,8'd6},
      '{1'b1,1'b0,1'b1,4'd2,32'h0001F297,1'b0,1'b0,1'b0,1'b0,32'h0001F297,8'd6},
      '{1'b1,1'b0,1'b0,4'd2,32'h00000000,1'b0,1'b0,1'b0,1'b0,32'h0001F297,8'd7},
      '{1'b1,1'b0,1'b0,4'd2,32'h00000000,1'b0,1'b0,1'b1,1'b1,32'h0001F297,8'd7},
      '{1'b1,1'b0,1'b0,4'd2,32'h00000000,1'b0,1'b0,1'b1,1'b0,32'h0001F297,8'd7},
      '{1'b1,1'b0,1'b0,4'd2,32'h00000000,1'b0,1'b1,1'b0,1'b0,32'h0001F293,8'd5},
      '{1'b1,1'b0,1'b1,4'd2,32'h0001F297,1'b1,1'b0,1'b0,1'b0,32'h0001D297,8'd4},
      '{1'b1,1'b0,1'b1,4'd5,32'h00000000,1'b0,1'b0,1'b0,1'b0,32'h00000000,8'd10},
      '{1'b1,1'b0,1'b0,4'd2,32'h00000000,1'b0,1'b0,1'b0,1'b0,32'h0001D297,8'd10},
      '{1'b0,1'b0,1'b0,4'd2,32'h00000000,1'b0,1'b0,1'b0,1'b0,32'h0001D296,8'd8},
      '{1'b0,1'b0,1'b1,4'd2,32'h00000000,1'b0,1'b0,1'b0,1'b0,32'h00000000,8'd2},
      '{1'b1,1'b0,1'b1,4'd2,32'h00000001,1'b0,1'b0,1'b1,1'b0,32'h00000001,8'd6},
      '{1'b1,1'b0,1'b0,4'd2,32'h00000000,1'b0,1'b0,1'b1,1'b1,32'h00000001,8'd7},
      '{1'b1,1'b0,1'b1,4'd2,32'h00000005,1'b0,1'b1,1'b0,1'b0,32'h00000001,8'd5}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      bus_wr = 1'b0; bus_addr = 4'd2; bus_wdata = '0;
      dpsm_active = 1'b0; xfer_done = 1'b0; rw_exit = 1'b0;
      err_or_hold = 1'b0; dma_en = 1'b0;
   endtask

   task automatic wr_cycle(input logic [31:0] d);
      @(negedge clk);
      idle_inputs();
      bus_wr = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", bus_rdata, 32'h0);
      chk("R1 flush", {31'b0, fifo_flush}, 32'h0);
      chk("R1 outs", {22'b0, xfer_en, dir_c2h, xfer_mode, blk_code, rw_start, rw_stop, rw_clk_stop, sdio_irq_en}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         dpsm_active = TBL[i].act; dma_en = TBL[i].dma; bus_wr = TBL[i].wr;
         bus_addr = TBL[i].addr; bus_wdata = TBL[i].wdata; xfer_done = TBL[i].done;
         rw_exit = TBL[i].rwx; err_or_hold = TBL[i].err;
         #1;
         chk($sformatf("R7 vec%0d flush (R%0d)", i, TBL[i].req), {31'b0, fifo_flush}, {31'b0, TBL[i].exp_flush});
         @(posedge clk); #1;
         chk($sformatf("R%0d vec%0d rdata", TBL[i].req, i), bus_rdata, TBL[i].exp_rd);
      end

      // R2 decoded outputs and R9 length for code 9
      wr_cycle(32'h0001F290);
      chk("R2 dir_c2h", {31'b0, dir_c2h}, 32'h1);
      chk("R2 mode", {30'b0, xfer_mode}, 32'h2);
      chk("R2 flags", {28'b0, xfer_en, rw_clk_stop, sdio_irq_en, boot_ack_en}, 32'hF);
      chk("R9 len code9", {17'b0, blk_len}, 32'd512);
      wr_cycle(32'h000000E0);
      chk("R9 len code14", {17'b0, blk_len}, 32'd16384);
      wr_cycle(32'h000000F0);
      chk("R9 len code15", {17'b0, blk_len}, 32'd0);
      wr_cycle(32'h00000000);
      chk("R9 len code0", {17'b0, blk_len}, 32'd1);

      // R10 write to address 0 ignored
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0001F2F6;
      @(posedge clk); #1;
      chk("R10 rd other addr", bus_rdata, 32'h0);
      bus_wr = 1'b0; bus_addr = 4'd2; #1;
      chk("R10 reg unchanged", bus_rdata, 32'h0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule